// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block is a small translation cache placed in front of a page-table walker. It keeps recently used virtual-page-to-physical-frame pairs. A lookup presents a full virtual address. The low bits form the page offset and pass through untouched. The upper bits form the virtual page number, which is compared against the tag of every valid entry at once. On a match, the physical address is formed in the same cycle by joining the stored frame number with the offset. On no match, a miss flag tells an external walker to resolve the page through the page table.

When the walker finds the page present, it writes the page and frame pair through the fill port. The walker never issues a fill for a faulting page. A fill lands in one of three places, in this order of preference:
- the entry that already holds the same page, so that no tag is ever stored twice;
- otherwise the lowest-numbered empty entry;
- otherwise the entry named by a round-robin victim pointer.

A flush input empties the whole cache in one cycle.

Top module: `xlate_cache`

## Requirements
- R1: The virtual address is split into a page offset (the low OFS_W bits, 12 by default for a 4 KB page) and a page number (the upper VPN_W bits). On a hit, lk_paddr equals {stored frame, offset}, with the frame in the upper PFN_W bits and the unchanged offset in the low OFS_W bits.
- R2: When lk_valid is high and any valid entry's tag equals the page number, lk_hit is high in the same cycle, with no clock edge between the address and the result.
- R3: When lk_valid is high and no valid entry matches, lk_miss is high, lk_hit is low and lk_paddr is zero. When lk_valid is low, lk_hit and lk_miss are both low.
- R4: A fill with fill_en high, presented at a clock edge, is visible to lookups from that edge on. A lookup of the same page in the cycle before that edge still misses.
- R5: After reset, every entry is invalid, so every lookup misses.
- R6: A flush empties every entry at the next edge and returns the victim pointer to entry 0. A fill presented in the same cycle as a flush is discarded.
- R7: A fill whose page already sits in a valid entry overwrites that entry's frame. No other entry changes, and the victim pointer does not move.
- R8: A fill of a new page goes to the lowest-numbered invalid entry if any entry is invalid.
- R9: A fill of a new page into a full cache replaces the entry named by the victim pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0. It moves only on such a replacement.
- R10: Lookups never change the cache contents. No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| fill_en | input | 1 | Write a page/frame pair |
| fill_vpn | input | VPN_W | Page number to write |
| fill_pfn | input | PFN_W | Frame number to write |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request present, no translation |
| lk_paddr | output | PFN_W+OFS_W | Physical address, zero unless hit |

## Verification
On every cycle, the assertions check the following:
- hit and miss are exclusive;
- the offset passes through unchanged on a hit;
- no two valid entries ever share a tag;
- a flush leaves the cache empty;
- lookups alone never change the valid set;
- a page filled at one edge translates to its new frame right after it.

The order in which entries are chosen cannot be seen by any single-cycle property. Lowest-invalid placement, round-robin eviction, and the pointer staying put on an overwrite or returning to zero on a flush show only in the bench's scenarios. There, fills beyond capacity reveal which older page was displaced.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFS_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PFN_W+OFS_W-1:0] lk_paddr
);
  localparam int VA_W  = VPN_W + OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            vld;
  logic [ENTRIES-1:0][VPN_W-1:0] tag;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn;
  logic [IDX_W-1:0]              ptr;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic [PFN_W-1:0]   hit_pfn;
  logic [IDX_W-1:0]   widx;
  logic               use_victim;

  assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld[g] && (tag[g] == lk_vpn);
    assign fl_match[g] = vld[g] && (tag[g] == fill_vpn);
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) hit_pfn = hit_pfn | pfn[i];
  end

  assign lk_hit   = lk_valid && (|lk_match);
  assign lk_miss  = lk_valid && !(|lk_match);
  assign lk_paddr = lk_hit ? {hit_pfn, lk_vaddr[OFS_W-1:0]} : '0;

  always_comb begin
    widx       = ptr;
    use_victim = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        widx       = IDX_W'(i);
        use_victim = 1'b0;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (fl_match[i]) begin
        widx       = IDX_W'(i);
        use_victim = 1'b0;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill_en) begin
      vld[widx] <= 1'b1;
      if (use_victim)
        ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && fill_en) begin
      tag[widx] <= fill_vpn;
      pfn[widx] <= fill_pfn;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFS_W   = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            flush,
  input logic                            fill_en,
  input logic [VPN_W-1:0]                fill_vpn,
  input logic [PFN_W-1:0]                fill_pfn,
  input logic                            lk_valid,
  input logic [VPN_W+OFS_W-1:0]          lk_vaddr,
  input logic                            lk_hit,
  input logic                            lk_miss,
  input logic [PFN_W+OFS_W-1:0]          lk_paddr,
  input logic [ENTRIES-1:0]              vld,
  input logic [ENTRIES-1:0][VPN_W-1:0]   tag
);
  localparam int VA_W = VPN_W + OFS_W;
  localparam int PA_W = PFN_W + OFS_W;

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss)); // R3

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0])); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (vld == '0)); // R6

  AST_LOOKUP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fill_en) && !$past(flush)) |-> $stable(vld)); // R10

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(fill_en && !flush) && lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn))
      |-> (lk_hit && lk_paddr[PA_W-1:OFS_W] == $past(fill_pfn))); // R4

  for (genvar a = 0; a < ENTRIES; a++) begin : g_a
    for (genvar b = a + 1; b < ENTRIES; b++) begin : g_b
      AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld[a] && vld[b] && tag[a] == tag[b])); // R10
    end
  end
endmodule

bind xlate_cache xlate_cache_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/test_xlate_cache.sv
module test_xlate_cache;
  localparam int N = 8, VW = 20, PW = 20, OW = 12;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, fill_en = 1'b0, lk_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [VW+OW-1:0] lk_vaddr = '0;
  logic lk_hit, lk_miss;
  logic [PW+OW-1:0] lk_paddr;
  int total = 0, bad = 0;

  logic          m_vld [N];
  logic [VW-1:0] m_tag [N];
  logic [PW-1:0] m_pfn [N];
  int            m_ptr;

  always #2 clk = ~clk;

  xlate_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .OFS_W(OW)) i_xlate_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int pfn_of(input int v);
    return (v * 7 + 3) % (1 << PW);
  endfunction

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic m_fill(input logic [VW-1:0] v, input logic [PW-1:0] p);
    int w = -1;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == v) w = i;
    if (w < 0) for (int i = 0; i < N; i++) if (!m_vld[i] && w < 0) w = i;
    if (w < 0) begin w = m_ptr; m_ptr = (m_ptr + 1) % N; end
    m_vld[w] = 1'b1; m_tag[w] = v; m_pfn[w] = p;
  endtask

  // present a lookup and compare with the model in the same cycle
  task automatic look(input logic [VW-1:0] v, input logic [OW-1:0] o, input string req);
    logic hit_e = 1'b0;
    logic [PW+OW-1:0] pa_e = '0;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {v, o};
    #1;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_tag[i] == v) begin hit_e = 1'b1; pa_e = {m_pfn[i], o}; end
    chk(lk_hit == hit_e && lk_miss == !hit_e, req, {62'd0, lk_hit, lk_miss}, {62'd0, hit_e, !hit_e});
    chk(lk_paddr == pa_e, req, 64'(lk_paddr), 64'(pa_e));
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input bit fl);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_pfn = p; flush = fl;
    @(posedge clk); #1;
    fill_en = 1'b0; flush = 1'b0;
    if (fl) m_clear(); else m_fill(v, p);
  endtask

  task automatic sweep(input int base, input int cnt, input string req);
    for (int k = 0; k < cnt; k++)
      look(VW'(base + k), OW'((base + k) * 37 + k), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R5: empty after reset; R3: misses, and idle lookup is silent
    sweep(0, 16, "R5 R3 reset miss");
    @(negedge clk); lk_valid = 1'b0; #1;
    chk(!lk_hit && !lk_miss, "R3 idle", {62'd0, lk_hit, lk_miss}, 64'd0);

    // R8: fill empty entries; R1 R2: hits with offset sweep
    for (int v = 16; v < 24; v++) fill(VW'(v), PW'(pfn_of(v)), 1'b0);
    sweep(0, 32, "R2 R1 R3 full sweep");
    for (int o = 0; o < 4096; o += 273) look(VW'(19), OW'(o), "R1 offset");
    look(VW'(23), 12'hFFF, "R1 max offset");

    // R9: full cache evicts round robin, oldest first
    fill(VW'(100), PW'(pfn_of(100)), 1'b0);
    look(VW'(16), 12'h0, "R9 evict entry0");
    fill(VW'(101), PW'(pfn_of(101)), 1'b0);
    look(VW'(17), 12'h1, "R9 evict entry1");

    // R7: overwrite in place, pointer unmoved
    fill(VW'(20), PW'(20'hABCDE), 1'b0);
    look(VW'(20), 12'h123, "R7 overwrite frame");
    fill(VW'(102), PW'(pfn_of(102)), 1'b0);
    look(VW'(18), 12'h2, "R7 R9 pointer held");
    sweep(16, 16, "R7 R9 sweep");
    sweep(100, 4, "R9 sweep new");

    // R4: same-cycle lookup sees old state, next cycle sees fill
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = VW'(555); fill_pfn = PW'(777);
    lk_valid = 1'b1; lk_vaddr = {VW'(555), OW'(12'h0AB)};
    #1;
    chk(lk_miss && !lk_hit, "R4 before edge", {62'd0, lk_hit, lk_miss}, 64'd1);
    @(posedge clk); #1;
    fill_en = 1'b0; m_fill(VW'(555), PW'(777));
    chk(lk_hit && lk_paddr == {PW'(777), OW'(12'h0AB)}, "R4 after edge",
        64'(lk_paddr), 64'({PW'(777), OW'(12'h0AB)}));

    // R10: a long run of lookups changes nothing
    for (int k = 0; k < 200; k++) look(VW'(k % 40 + 90), OW'(k), "R10 lookup run");
    sweep(16, 16, "R10 contents kept");
    sweep(100, 4, "R10 contents kept");

    // R6: flush empties, flush beats fill, pointer back to entry 0
    fill(VW'(200), PW'(1), 1'b1);
    look(VW'(200), 12'h0, "R6 fill dropped");
    sweep(16, 16, "R6 flush empty");
    sweep(100, 4, "R6 flush empty");
    for (int v = 300; v < 309; v++) fill(VW'(v), PW'(pfn_of(v)), 1'b0);
    look(VW'(300), 12'h0, "R6 R9 pointer reset");
    look(VW'(301), 12'h0, "R8 R9 second kept");
    sweep(300, 9, "R8 post flush sweep");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule